// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns code-fetch, data-read and data-write requests from a 16-bit controller core into strobe sequences on a multiplexed address/data memory bus. Each request carries a kind, an address, a byte/word select and write data. For a normal cycle the sequencer first shows the upper address on the shared bus under an address-latch strobe. It then runs one access strobe: a fetch strobe for code, a read strobe for data reads, or one or two byte-lane write strobes for writes. The lowest address nibble has its own pins and is never multiplexed. The length of each strobe comes from a programmable field, and the field values are captured when the request is accepted.

Code fetches that follow one another in address order, inside one 16-byte aligned block, can skip the address phase. This is a burst. When the next sequential fetch is already waiting during the last clock of the current fetch strobe, the fetch strobe stays high without a break. Every other cycle ends with one clock of complete bus silence. A branch cuts an in-flight fetch short. A disable input keeps the sequencer from starting any cycle.

Top module: `ebs_seq`

## Requirements
- R1: A full cycle holds `ale` for `cfg_ale_w`+1 clocks and then its access strobe for field+1 clocks. The field is `cfg_code_w` for `psen`, `cfg_rd_w` for `rd` and `cfg_wr_w` for `wrl`/`wrh`. At most one of these strobe kinds is high in any clock.
- R2: The timing fields are sampled in the clock that accepts a request (`req_valid` and `req_ready` both high). A change after that point does not alter the running cycle.
- R3: For a write accepted while `cfg_wr_hold`=1, the write data stays on `ad_out` with `ad_oe`=1 for exactly one extra clock after the write strobe ends, with no strobe high.
- R4: After any strobe falls, the next clock has no `ale`, `psen`, `rd`, `wrl` or `wrh`. A code fetch that follows a fetch strobe back to back, with no chained burst, sees exactly one fully quiet clock before its address phase.
- R5: During `ale`, `ad_out` carries address bits [ADDR_W-1:4], zero-extended, with `ad_oe`=1. `a_low` shows address bits [3:0] for the whole cycle.
- R6: A code fetch skips the address phase if its address equals the previous fetch address plus 1 (byte) or 2 (word), lies in the same 16-byte aligned block, and no data access, abort or branch came in between. This holds even after idle clocks.
- R7: If such a sequential fetch is presented during the last clock of a fetch strobe, it is accepted in that clock and `psen` stays high with no gap.
- R8: A fetch that is non-sequential, or that crosses into another 16-byte block, starts with an address phase.
- R9: Kind encoding is 00 code, 01 data read, 10 data write, 11 treated as data read. Every data access uses an address phase, and the first code fetch after it also uses one.
- R10: `branch` during the address phase or fetch strobe of a code cycle ends it at the next edge. `aborted` then pulses for one clock, no `done` follows, and the next fetch needs an address phase.
- R11: While `bus_off`=1, `req_ready` is 0 and no cycle starts.
- R12: A word write raises `wrl` and `wrh` together. A byte write raises only `wrl` when address bit 0 is 0, and only `wrh` when it is 1. The write data is driven on `ad_out` during the strobe.
- R13: `done` pulses for one clock right after the final strobe clock. `rdata` then holds `ad_in` as sampled in that final clock.
- R14: After reset all strobes, `ad_oe`, `done` and `aborted` are 0, and `req_ready` is 1 when `bus_off`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 code, 01 read, 10 write, 11 read |
| req_addr | input | ADDR_W | Byte address |
| req_word | input | 1 | 1 word, 0 byte |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted this clock if valid |
| branch | input | 1 | Abort fetch in flight, break burst |
| bus_off | input | 1 | Inhibit new cycles |
| cfg_ale_w | input | TW | Address strobe width minus one |
| cfg_code_w | input | TW | Fetch strobe width minus one |
| cfg_rd_w | input | TW | Read strobe width minus one |
| cfg_wr_w | input | TW | Write strobe width minus one |
| cfg_wr_hold | input | 1 | Extend write data one clock |
| ale | output | 1 | Address latch strobe |
| psen | output | 1 | Code fetch strobe |
| rd | output | 1 | Data read strobe |
| wrl | output | 1 | Low-lane write strobe |
| wrh | output | 1 | High-lane write strobe |
| ad_out | output | DATA_W | Multiplexed bus, outbound |
| ad_oe | output | 1 | Bus drive enable |
| ad_in | input | DATA_W | Multiplexed bus, inbound |
| a_low | output | 4 | Non-multiplexed address nibble |
| done | output | 1 | Access completed |
| rdata | output | DATA_W | Read data of completed access |
| aborted | output | 1 | Fetch cut short |

## Verification
The bench builds the block with its defaults: a 16-bit bus, 20-bit address and 3-bit timing fields. Under these defaults the upper address fills the whole multiplexed bus, and strobe lengths from 1 to 8 clocks are reachable. The vectors program the unused timing fields to the maximum, so a strobe that takes its width from the wrong field shows a wrong length. Directed tests cover chained bursts, the block crossing at 0x110, aborts in both phases and mid-cycle field changes.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   typedef enum logic [1:0] {
      K_CODE = 2'b00,
      K_DRD  = 2'b01,
      K_DWR  = 2'b10,
      K_RSV  = 2'b11
   } kind_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_ADDR = 2'd1,
      S_STRB = 2'd2,
      S_HOLD = 2'd3
   } phase_e;

endpackage

// File: rtl/ebs_timer.sv
module ebs_timer #(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/ebs_burst.sv
module ebs_burst #(
   parameter int ADDR_W = 20,
   parameter int NIB    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              note,
   input  logic [ADDR_W-1:0] note_addr,
   input  logic              note_word,
   input  logic              drop,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              hit
);
   localparam int UPW = ADDR_W - NIB;

   logic              vld;
   logic [ADDR_W-1:0] nxt;
   logic [UPW-1:0]    blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= 1'b0;
         nxt <= '0;
         blk <= '0;
      end else if (note) begin
         vld <= 1'b1;
         nxt <= note_addr + (note_word ? ADDR_W'(2) : ADDR_W'(1));
         blk <= note_addr[ADDR_W-1:NIB];
      end else if (drop) begin
         vld <= 1'b0;
      end
   end

   assign hit = vld && (probe_addr == nxt) && (probe_addr[ADDR_W-1:NIB] == blk);
endmodule

// File: rtl/ebs_lanes.sv
module ebs_lanes #(
   parameter int NL = 2
) (
   input  logic          on,
   input  logic          word,
   input  logic          a0,
   output logic [NL-1:0] en
);
   for (genvar i = 0; i < NL; i++) begin : g_lane
      localparam bit LSEL = 1'(i % 2);
      assign en[i] = on && (word || (a0 == LSEL));
   end
endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
   import ebs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 20,
   parameter int TW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   input  logic              branch,
   input  logic              bus_off,
   input  logic [TW-1:0]     cfg_ale_w,
   input  logic [TW-1:0]     cfg_code_w,
   input  logic [TW-1:0]     cfg_rd_w,
   input  logic [TW-1:0]     cfg_wr_w,
   input  logic              cfg_wr_hold,
   output logic              ale,
   output logic              psen,
   output logic              rd,
   output logic              wrl,
   output logic              wrh,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic [3:0]        a_low,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              aborted
);
   localparam int NIB = 4;
   localparam int UPW = ADDR_W - NIB;
   localparam int NL  = DATA_W / 8;

   if (DATA_W != 16) begin : g_bad_dw
      $error("ebs_seq: DATA_W must be 16");
   end
   if (ADDR_W < NIB + 1 || ADDR_W > DATA_W + NIB) begin : g_bad_aw
      $error("ebs_seq: ADDR_W out of range");
   end
   if (TW < 1) begin : g_bad_tw
      $error("ebs_seq: TW must be at least 1");
   end

   phase_e            phase, phase_nx;
   kind_e             cur_kind, in_kind;
   logic [ADDR_W-1:0] cur_addr;
   logic              cur_word;
   logic [DATA_W-1:0] cur_wdata;
   logic [TW-1:0]     cur_sw;
   logic              cur_hold;
   logic              done_q, abt_q;
   logic [DATA_W-1:0] rdata_q;

   logic              is_code, is_wr, in_code;
   logic              hit, burst_go, chain_ok, accept, abort_now;
   logic              tmr_zero, tmr_load;
   logic [TW-1:0]     tmr_val, sel_sw;
   logic [NL-1:0]     lane_en;
   logic [DATA_W-1:0] up_bus;

   assign in_kind  = kind_e'(req_kind);
   assign is_code  = (cur_kind == K_CODE);
   assign is_wr    = (cur_kind == K_DWR);
   assign in_code  = is_code && (phase == S_ADDR || phase == S_STRB);
   assign abort_now = branch && in_code;

   assign burst_go = (in_kind == K_CODE) && hit && !branch;
   assign chain_ok = (phase == S_STRB) && tmr_zero && is_code && !branch &&
                     !bus_off && burst_go;
   assign req_ready = ((phase == S_IDLE) && !bus_off) || chain_ok;
   assign accept    = req_valid && req_ready;

   always_comb begin
      unique case (in_kind)
         K_CODE:  sel_sw = cfg_code_w;
         K_DWR:   sel_sw = cfg_wr_w;
         default: sel_sw = cfg_rd_w;
      endcase
   end

   always_comb begin
      phase_nx = phase;
      tmr_load = 1'b0;
      tmr_val  = cfg_ale_w;
      unique case (phase)
         S_IDLE: begin
            if (accept) begin
               tmr_load = 1'b1;
               if (burst_go) begin
                  phase_nx = S_STRB;
                  tmr_val  = sel_sw;
               end else begin
                  phase_nx = S_ADDR;
               end
            end
         end
         S_ADDR: begin
            if (abort_now) begin
               phase_nx = S_IDLE;
            end else if (tmr_zero) begin
               phase_nx = S_STRB;
               tmr_load = 1'b1;
               tmr_val  = cur_sw;
            end
         end
         S_STRB: begin
            if (abort_now) begin
               phase_nx = S_IDLE;
            end else if (tmr_zero) begin
               if (accept) begin
                  phase_nx = S_STRB;
                  tmr_load = 1'b1;
                  tmr_val  = sel_sw;
               end else if (is_wr && cur_hold) begin
                  phase_nx = S_HOLD;
               end else begin
                  phase_nx = S_IDLE;
               end
            end
         end
         default: phase_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= S_IDLE;
         cur_kind  <= K_CODE;
         cur_addr  <= '0;
         cur_word  <= 1'b0;
         cur_wdata <= '0;
         cur_sw    <= '0;
         cur_hold  <= 1'b0;
         done_q    <= 1'b0;
         abt_q     <= 1'b0;
         rdata_q   <= '0;
      end else begin
         phase  <= phase_nx;
         done_q <= (phase == S_STRB) && tmr_zero && !abort_now;
         abt_q  <= abort_now;
         if ((phase == S_STRB) && tmr_zero && !abort_now)
            rdata_q <= ad_in;
         if (accept) begin
            cur_kind  <= in_kind;
            cur_addr  <= req_addr;
            cur_word  <= req_word;
            cur_wdata <= req_wdata;
            cur_sw    <= sel_sw;
            cur_hold  <= cfg_wr_hold;
         end
      end
   end

   ebs_timer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   ebs_burst #(.ADDR_W(ADDR_W), .NIB(NIB)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .note       (accept && (in_kind == K_CODE)),
      .note_addr  (req_addr),
      .note_word  (req_word),
      .drop       (branch || (accept && (in_kind != K_CODE))),
      .probe_addr (req_addr),
      .hit        (hit)
   );

   ebs_lanes #(.NL(NL)) u_lanes (
      .on   ((phase == S_STRB) && is_wr),
      .word (cur_word),
      .a0   (cur_addr[0]),
      .en   (lane_en)
   );

   if (UPW == DATA_W) begin : g_up_full
      assign up_bus = cur_addr[ADDR_W-1:NIB];
   end else begin : g_up_pad
      assign up_bus = {{(DATA_W-UPW){1'b0}}, cur_addr[ADDR_W-1:NIB]};
   end

   assign ale     = (phase == S_ADDR);
   assign psen    = (phase == S_STRB) && is_code;
   assign rd      = (phase == S_STRB) && !is_code && !is_wr;
   assign wrl     = lane_en[0];
   assign wrh     = lane_en[NL-1];
   assign ad_oe   = ale || (is_wr && (phase == S_STRB || phase == S_HOLD));
   assign ad_out  = ale ? up_bus : cur_wdata;
   assign a_low   = cur_addr[NIB-1:0];
   assign done    = done_q;
   assign rdata   = rdata_q;
   assign aborted = abt_q;
endmodule

// File: rtl/ebs_seq_chk.sv
module ebs_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_off,
   input logic ale,
   input logic psen,
   input logic rd,
   input logic wrl,
   input logic wrh,
   input logic ad_oe,
   input logic done,
   input logic aborted
);
   // R1
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ale, psen, rd, wrl | wrh}));

   // R4
   rest_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd | wrl | wrh) |-> !(ale | psen | rd | wrl | wrh));

   // R4
   rest_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(psen) |-> !(ale | psen | rd | wrl | wrh));

   // R10
   abort_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aborted |-> !done);

   // R13
   done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(psen | rd | wrl | wrh));

   // R12
   write_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrl | wrh) |-> ad_oe);

   // R11
   no_start_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |-> !$past(bus_off));
endmodule

bind ebs_seq ebs_seq_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_off (bus_off),
   .ale     (ale),
   .psen    (psen),
   .rd      (rd),
   .wrl     (wrl),
   .wrh     (wrh),
   .ad_oe   (ad_oe),
   .done    (done),
   .aborted (aborted)
);

// File: tb/tb_ebs_seq.sv
`timescale 1ns/1ps
module tb_ebs_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [19:0] req_addr = '0;
   logic        req_word = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic        branch = 1'b0;
   logic        bus_off = 1'b0;
   logic [2:0]  cfg_ale_w = 3'd0, cfg_code_w = 3'd0, cfg_rd_w = 3'd0, cfg_wr_w = 3'd0;
   logic        cfg_wr_hold = 1'b0;
   logic        ale, psen, rd, wrl, wrh, ad_oe, done, aborted;
   logic [15:0] ad_out, ad_in, rdata;
   logic [3:0]  a_low;

   always #4 clk = ~clk;

   assign ad_in = {12'hBEE, a_low};

   ebs_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
      .req_ready(req_ready), .branch(branch), .bus_off(bus_off),
      .cfg_ale_w(cfg_ale_w), .cfg_code_w(cfg_code_w), .cfg_rd_w(cfg_rd_w),
      .cfg_wr_w(cfg_wr_w), .cfg_wr_hold(cfg_wr_hold), .ale(ale), .psen(psen),
      .rd(rd), .wrl(wrl), .wrh(wrh), .ad_out(ad_out), .ad_oe(ad_oe),
      .ad_in(ad_in), .a_low(a_low), .done(done), .rdata(rdata), .aborted(aborted)
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [19:0] addr;
      logic        word;
      logic [15:0] wdata;
      logic [2:0]  aw;
      logic [2:0]  sw;
      logic        hold;
      logic        burst;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VT [NV] = '{
      '{2'd0, 20'h00100, 1'b1, 16'h0000, 3'd1, 3'd2, 1'b0, 1'b0},
      '{2'd0, 20'h00102, 1'b1, 16'h0000, 3'd1, 3'd1, 1'b0, 1'b1},
      '{2'd0, 20'h00103, 1'b0, 16'h0000, 3'd0, 3'd0, 1'b0, 1'b0},
      '{2'd0, 20'h00104, 1'b0, 16'h0000, 3'd0, 3'd0, 1'b0, 1'b1},
      '{2'd1, 20'h2345A, 1'b1, 16'h0000, 3'd2, 3'd3, 1'b0, 1'b0},
      '{2'd0, 20'h00105, 1'b0, 16'h0000, 3'd0, 3'd1, 1'b0, 1'b0},
      '{2'd2, 20'h00200, 1'b1, 16'h1234, 3'd0, 3'd1, 1'b1, 1'b0},
      '{2'd2, 20'h00201, 1'b0, 16'h00AB, 3'd1, 3'd2, 1'b0, 1'b0},
      '{2'd2, 20'h00200, 1'b0, 16'h00CD, 3'd0, 3'd0, 1'b0, 1'b0},
      '{2'd0, 20'h0010E, 1'b1, 16'h0000, 3'd0, 3'd0, 1'b0, 1'b0},
      '{2'd0, 20'h00110, 1'b1, 16'h0000, 3'd0, 3'd0, 1'b0, 1'b0},
      '{2'd0, 20'h00112, 1'b1, 16'h0000, 3'd2, 3'd0, 1'b0, 1'b1},
      '{2'd3, 20'h00033, 1'b0, 16'h0000, 3'd1, 3'd1, 1'b0, 1'b0}
   };

   int n_chk = 0, n_fail = 0;
   int n_ale, n_psen, n_rd, n_wrl, n_wrh, n_hold, n_done, n_abt, n_pfall;
   int quiet, last_gap, seen;
   logic        prev_psen = 1'b0;
   logic [15:0] ad_at_ale, ad_at_wr;

   always @(negedge clk) begin
      if (ale) begin n_ale++; ad_at_ale = ad_out; end
      if (psen) n_psen++;
      if (rd) n_rd++;
      if (wrl) n_wrl++;
      if (wrh) n_wrh++;
      if (wrl | wrh) ad_at_wr = ad_out;
      if (ad_oe && !ale && !wrl && !wrh) n_hold++;
      if (done) n_done++;
      if (aborted) n_abt++;
      if (prev_psen && !psen) n_pfall++;
      prev_psen = psen;
      if (ale | psen | rd | wrl | wrh | ad_oe) begin
         if (seen != 0 && quiet > 0) last_gap = quiet;
         quiet = 0;
         seen = 1;
      end else if (seen != 0) begin
         quiet++;
      end
   end

   task automatic clr_mon();
      n_ale = 0; n_psen = 0; n_rd = 0; n_wrl = 0; n_wrh = 0; n_hold = 0;
      n_done = 0; n_abt = 0; n_pfall = 0; quiet = 0; last_gap = -1; seen = 0;
      ad_at_ale = '0; ad_at_wr = '0;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic wait_accept();
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_done(input int target);
      for (int i = 0; i < 200; i++) begin
         if (n_done >= target) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic set_req(input logic [1:0] k, input logic [19:0] a, input logic w,
                          input logic [15:0] d);
      req_kind = k; req_addr = a; req_word = w; req_wdata = d; req_valid = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      clr_mon();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R14 reset state
      chk("R14 strobes idle", int'({ale, psen, rd, wrl, wrh}), 0);
      chk("R14 ad_oe low", int'(ad_oe), 0);
      chk("R14 done/aborted low", int'({done, aborted}), 0);
      chk("R14 ready high", int'(req_ready), 1);
      @(negedge clk);

      // Table walk: R1 R5 R6 R8 R9 R12 R13 R3
      for (int v = 0; v < NV; v++) begin
         vec_t t;
         int sl, e_ale, e_ps, e_rd, e_wl, e_wh, e_hd;
         t = VT[v];
         cfg_ale_w  = t.aw;
         cfg_code_w = (t.kind == 2'd0) ? t.sw : 3'd7;
         cfg_rd_w   = (t.kind == 2'd1 || t.kind == 2'd3) ? t.sw : 3'd7;
         cfg_wr_w   = (t.kind == 2'd2) ? t.sw : 3'd7;
         cfg_wr_hold = t.hold;
         sl    = int'(t.sw) + 1;
         e_ale = t.burst ? 0 : int'(t.aw) + 1;
         e_ps  = (t.kind == 2'd0) ? sl : 0;
         e_rd  = (t.kind == 2'd1 || t.kind == 2'd3) ? sl : 0;
         e_wl  = (t.kind == 2'd2 && (t.word || !t.addr[0])) ? sl : 0;
         e_wh  = (t.kind == 2'd2 && (t.word || t.addr[0])) ? sl : 0;
         e_hd  = (t.kind == 2'd2 && t.hold) ? 1 : 0;
         clr_mon();
         set_req(t.kind, t.addr, t.word, t.wdata);
         wait_accept();
         req_valid = 1'b0;
         wait_done(1);
         chk($sformatf("R1/R6/R8/R9 vec%0d ale clocks", v), n_ale, e_ale);
         chk($sformatf("R1 vec%0d psen clocks", v), n_psen, e_ps);
         chk($sformatf("R1/R9 vec%0d rd clocks", v), n_rd, e_rd);
         chk($sformatf("R12 vec%0d wrl clocks", v), n_wrl, e_wl);
         chk($sformatf("R12 vec%0d wrh clocks", v), n_wrh, e_wh);
         chk($sformatf("R3 vec%0d hold clocks", v), n_hold, e_hd);
         chk($sformatf("R13 vec%0d done pulses", v), n_done, 1);
         if (e_ale != 0)
            chk($sformatf("R5 vec%0d upper address", v), int'(ad_at_ale), int'(t.addr[19:4]));
         if (t.kind != 2'd2)
            chk($sformatf("R13/R5 vec%0d rdata", v), int'(rdata), int'({12'hBEE, t.addr[3:0]}));
         else
            chk($sformatf("R12 vec%0d write data", v), int'(ad_at_wr), int'(t.wdata));
      end

      // R7 chained burst: 0x108..0x10E back to back
      cfg_ale_w = 3'd0; cfg_code_w = 3'd1; cfg_wr_hold = 1'b0;
      clr_mon();
      set_req(2'd0, 20'h00108, 1'b1, 16'h0);
      wait_accept();
      for (int b = 1; b < 4; b++) begin
         req_addr = 20'h00108 + 20'(2 * b);
         wait_accept();
      end
      req_valid = 1'b0;
      wait_done(4);
      chk("R7 chain ale clocks", n_ale, 1);
      chk("R7 chain psen clocks", n_psen, 8);
      chk("R7 chain psen falls", n_pfall, 1);
      chk("R7 chain done pulses", n_done, 4);

      // R4 quiet clock between fetch and following data read
      clr_mon();
      set_req(2'd0, 20'h00300, 1'b1, 16'h0);
      wait_accept();
      set_req(2'd1, 20'h00400, 1'b1, 16'h0);
      wait_accept();
      req_valid = 1'b0;
      wait_done(2);
      chk("R4 quiet clocks before address phase", last_gap, 1);

      // R2 timing capture at acceptance
      cfg_rd_w = 3'd1;
      clr_mon();
      set_req(2'd1, 20'h00410, 1'b1, 16'h0);
      wait_accept();
      cfg_rd_w = 3'd5;
      req_valid = 1'b0;
      wait_done(1);
      chk("R2 rd clocks after field change", n_rd, 2);

      // R10 abort during fetch strobe
      cfg_ale_w = 3'd0; cfg_code_w = 3'd3;
      clr_mon();
      set_req(2'd0, 20'h00500, 1'b1, 16'h0);
      wait_accept();
      req_valid = 1'b0;
      for (int i = 0; i < 20 && !psen; i++) @(negedge clk);
      branch = 1'b1;
      @(negedge clk);
      branch = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 psen clocks after abort", n_psen, 1);
      chk("R10 aborted pulses", n_abt, 1);
      chk("R10 no done", n_done, 0);
      clr_mon();
      set_req(2'd0, 20'h00502, 1'b1, 16'h0);
      wait_accept();
      req_valid = 1'b0;
      wait_done(1);
      chk("R10 fetch after abort uses ale", n_ale, 1);

      // R10 abort during address phase
      cfg_ale_w = 3'd3;
      clr_mon();
      set_req(2'd0, 20'h00600, 1'b1, 16'h0);
      wait_accept();
      req_valid = 1'b0;
      for (int i = 0; i < 20 && !ale; i++) @(negedge clk);
      branch = 1'b1;
      @(negedge clk);
      branch = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 ale clocks after abort", n_ale, 1);
      chk("R10 no psen after abort in address phase", n_psen, 0);
      chk("R10 aborted pulse in address phase", n_abt, 1);

      // R11 bus disable
      bus_off = 1'b1;
      clr_mon();
      set_req(2'd0, 20'h00700, 1'b1, 16'h0);
      #1;
      chk("R11 ready low when disabled", int'(req_ready), 0);
      repeat (8) @(negedge clk);
      chk("R11 no cycle while disabled", n_ale + n_psen + n_rd, 0);
      req_valid = 1'b0;
      bus_off = 1'b0;
      repeat (2) @(negedge clk);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule